// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block arbitrates eight edge-triggered interrupt lines under a fixed priority, where line 0 ranks highest and line 7 lowest. Its host side is a byte-wide register port with one address bit and separate read and write strobes. The even address accepts command bytes and returns status. The odd address reaches the interrupt mask once setup is done.

Software programs the block with a short write sequence. A command byte with bit 4 set goes to the even address, and up to three parameter bytes then go to the odd address. Service is by polling. Software arms a poll with a command, and the next even-address read returns the winning level and marks it in service. A non-specific end-of-interrupt command retires the highest-ranked level in service.

A build parameter makes an instance either a master or a slave. Two instances can then be chained, with the slave's interrupt output feeding one of the master's lines.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `irq_out` is 0, an odd-address read returns 0xFF (every line masked), and an even-address read returns the request register, which is 0x00.
- R2: An even-address write with bit 4 set does four things. It clears the mask and in-service registers, selects the request register for status reads, and starts setup. The next odd write loads the vector base (bits 7:3 kept). The next one loads the cascade byte, unless bit 1 of the command was set. After that a mode byte is taken, only when bit 0 of the command was set. From then on, odd writes load the mask.
- R3: Once setup is done, an odd write loads the 8-bit mask, and a 1 bit blocks that line from `irq_out` and from polling. An odd read returns the mask.
- R4: The cascade byte drives `link_cfg`. On a master (`IS_SLAVE`=0) all 8 bits are stored. On a slave only bits 2:0 are stored, giving `link_cfg` = {5'b0, id}.
- R5: A rising edge on a line sets its request bit. The bit clears if the line falls before acknowledge, and it also clears on acknowledge. A line held high after acknowledge does not set the bit again.
- R6: `irq_out` is 1 exactly when the lowest-numbered unmasked pending line exists and is numbered below every in-service level.
- R7: An even write with bits 4:3 = 01 and bit 2 = 1 (for example 0x0C) arms a poll. The next even read returns {1, 4'b0, level} for the line that would raise `irq_out`. That read sets the level's in-service bit, clears its request bit and disarms the poll. Odd reads leave an armed poll untouched.
- R8: A poll read when no line is eligible returns 0x07 and sets no in-service bit. A line-7 request that falls before the poll therefore reads back as level 7, with in-service bit 7 clear.
- R9: An even write with bits 4:3 = 01 and bits 1:0 = 11 selects the in-service register for later even reads. Bits 1:0 = 10 selects the request register. With bit 1 = 0 (for example 0x0C) the selection is kept.
- R10: An even write with bits 4:3 = 00 and bits 7:5 = 001 (0x20) clears the lowest-numbered set in-service bit, and does nothing when none is set. Other codes in bits 7:5 leave the in-service register unchanged.
- R11: Each poll acknowledge does two things. It loads `ack_vector` with {base[7:3], level}. It sets `vec_own`, which is 1 on a slave and on a master is 1 unless that level's cascade bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_a0 | input | 1 | Register address bit: 0 for command/status, 1 for mask and setup bytes |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| irq_lines | input | NUM_LINES | Interrupt request lines, edge-sensed |
| irq_out | output | 1 | Interrupt request to the host or to a master |
| ack_vector | output | 8 | Vector of the last acknowledged level |
| vec_own | output | 1 | This instance supplies the vector for the last acknowledge |
| link_cfg | output | 8 | Stored cascade configuration |

## Verification
A sweep covers every request pattern under two masks. In each case it checks `irq_out`, the poll byte and the in-service bit that results. A design whose priority ran the wrong way, or that ignored the mask, would report the wrong level.

Directed cases cover three corner cases:
- A lower-ranked request arrives while a higher level is in service. A design without in-service gating would raise `irq_out` too early.
- An end-of-interrupt is issued with two levels in service. A design that cleared the whole register, or the wrong bit, would unblock the wrong level.
- A level-7 request vanishes before the poll. A design that set in-service bit 7 regardless would hide the spurious case from software.

Further cases cover the shortened setup sequences, which misplace the mask if a byte is skipped wrongly, and an odd read between poll command and poll read, which must not swallow the acknowledge.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   // setup sequencer states
   typedef enum logic [1:0] {
      CFG_IDLE = 2'd0,
      CFG_VEC  = 2'd1,
      CFG_LINK = 2'd2,
      CFG_MODE = 2'd3
   } cfg_state_e;

   // command code in bits 7:5 of an operation byte
   localparam logic [2:0] OP_NS_EOI = 3'b001;

   // bus width of the register port
   localparam int BUS_W = 8;

endpackage

// File: rtl/prio_irq_reqlatch.sv
module prio_irq_reqlatch #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lines_i,
   input  logic [N-1:0] ack_clr_i,
   output logic [N-1:0] irr_o
);

   logic [N-1:0] prev_q;
   logic [N-1:0] irr_q;
   logic [N-1:0] rise;

   assign rise = lines_i & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '1;
         irr_q  <= '0;
      end else begin
         prev_q <= lines_i;
         irr_q  <= (irr_q | rise) & lines_i & ~ack_clr_i;
      end
   end

   assign irr_o = irr_q;

   AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (|ack_clr_i) |=> ((irr_q & $past(ack_clr_i)) == '0)); // R5

   AST_LOW_LINE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((irr_q & ~$past(lines_i)) == '0)); // R5

endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver #(
   parameter int N  = 8,
   parameter int LW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  irr_i,
   input  logic [N-1:0]  imr_i,
   input  logic [N-1:0]  isr_i,
   output logic          grant_vld_o,
   output logic [LW-1:0] grant_lvl_o,
   output logic          isr_vld_o,
   output logic [LW-1:0] isr_lvl_o,
   output logic          irq_o
);

   logic [N-1:0]  pend;
   logic          p_vld;
   logic [LW-1:0] p_lvl;
   logic          s_vld;
   logic [LW-1:0] s_lvl;

   assign pend = irr_i & ~imr_i;

   // lowest index wins: scan downward so the last hit is the winner
   always_comb begin
      p_vld = 1'b0;
      p_lvl = '0;
      s_vld = 1'b0;
      s_lvl = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i]) begin
            p_vld = 1'b1;
            p_lvl = LW'(i);
         end
         if (isr_i[i]) begin
            s_vld = 1'b1;
            s_lvl = LW'(i);
         end
      end
   end

   assign grant_vld_o = p_vld && (!s_vld || (p_lvl < s_lvl));
   assign grant_lvl_o = p_lvl;
   assign isr_vld_o   = s_vld;
   assign isr_lvl_o   = s_lvl;
   assign irq_o       = grant_vld_o;

   AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((irr_i & ~imr_i) != '0)); // R6

   AST_IRQ_NOT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((isr_i & ~({N{1'b1}} << grant_lvl_o)) == '0) && !isr_i[grant_lvl_o]); // R6

endmodule

// File: rtl/prio_irq_seq.sv
module prio_irq_seq
   import prio_irq_pkg::*;
#(
   parameter int N        = 8,
   parameter int LW       = $clog2(N),
   parameter bit IS_SLAVE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             a0_i,
   input  logic             wr_i,
   input  logic             rd_i,
   input  logic [BUS_W-1:0] wdata_i,
   output logic [BUS_W-1:0] rdata_o,
   input  logic [N-1:0]     irr_i,
   input  logic             grant_vld_i,
   input  logic [LW-1:0]    grant_lvl_i,
   input  logic             isr_vld_i,
   input  logic [LW-1:0]    isr_lvl_i,
   output logic [N-1:0]     imr_o,
   output logic [N-1:0]     isr_o,
   output logic [N-1:0]     ack_clr_o,
   output logic [BUS_W-1:0] ack_vec_o,
   output logic             vec_own_o,
   output logic [BUS_W-1:0] link_cfg_o
);

   localparam int BASE_W = BUS_W - LW;
   localparam int PAD_W  = BUS_W - 1 - LW;

   cfg_state_e        st_q;
   logic              need_link_q;
   logic              need_mode_q;
   logic [BASE_W-1:0] base_q;
   logic [N-1:0]      imr_q;
   logic [N-1:0]      isr_q;
   logic              sel_isr_q;
   logic              poll_q;
   logic [BUS_W-1:0]  ack_vec_q;
   logic              vec_own_q;

   logic wr_even, wr_odd, rd_even;
   logic is_init, is_opsel, is_opcmd, is_eoi;
   logic ack;
   logic link_we;
   logic own_next;

   assign wr_even  = wr_i & ~a0_i;
   assign wr_odd   = wr_i & a0_i;
   assign rd_even  = rd_i & ~a0_i & ~wr_i;
   assign is_init  = wr_even & wdata_i[4];
   assign is_opsel = wr_even & ~wdata_i[4] & wdata_i[3];
   assign is_opcmd = wr_even & ~wdata_i[4] & ~wdata_i[3];
   assign is_eoi   = is_opcmd && (wdata_i[7:5] == OP_NS_EOI);
   assign ack      = rd_even & poll_q & grant_vld_i;
   assign link_we  = wr_odd && (st_q == CFG_LINK) && !is_init;

   assign ack_clr_o = ack ? (N'(1) << grant_lvl_i) : '0;

   // cascade role picks the stored form of the cascade byte
   generate
      if (IS_SLAVE) begin : g_slave
         logic [2:0] id_q;
         always_ff @(posedge clk) begin
            if (!rst_n)       id_q <= '0;
            else if (link_we) id_q <= wdata_i[2:0];
         end
         assign link_cfg_o = {{(BUS_W-3){1'b0}}, id_q};
         assign own_next   = 1'b1;
      end else begin : g_master
         logic [N-1:0] map_q;
         always_ff @(posedge clk) begin
            if (!rst_n)       map_q <= '0;
            else if (link_we) map_q <= wdata_i[N-1:0];
         end
         assign link_cfg_o = BUS_W'(map_q);
         assign own_next   = ~map_q[grant_lvl_i];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= CFG_IDLE;
         need_link_q <= 1'b0;
         need_mode_q <= 1'b0;
         base_q      <= '0;
         imr_q       <= '1;
         isr_q       <= '0;
         sel_isr_q   <= 1'b0;
         poll_q      <= 1'b0;
         ack_vec_q   <= '0;
         vec_own_q   <= 1'b0;
      end else if (is_init) begin
         st_q        <= CFG_VEC;
         need_link_q <= ~wdata_i[1];
         need_mode_q <= wdata_i[0];
         imr_q       <= '0;
         isr_q       <= '0;
         sel_isr_q   <= 1'b0;
         poll_q      <= 1'b0;
      end else if (is_opsel) begin
         if (wdata_i[2]) poll_q    <= 1'b1;
         if (wdata_i[1]) sel_isr_q <= wdata_i[0];
      end else if (is_opcmd) begin
         if (is_eoi && isr_vld_i) isr_q[isr_lvl_i] <= 1'b0;
      end else if (wr_odd) begin
         unique case (st_q)
            CFG_IDLE: imr_q <= wdata_i[N-1:0];
            CFG_VEC: begin
               base_q <= wdata_i[BUS_W-1:LW];
               if (need_link_q)      st_q <= CFG_LINK;
               else if (need_mode_q) st_q <= CFG_MODE;
               else                  st_q <= CFG_IDLE;
            end
            CFG_LINK: st_q <= need_mode_q ? CFG_MODE : CFG_IDLE;
            CFG_MODE: st_q <= CFG_IDLE;
            default:  st_q <= CFG_IDLE;
         endcase
      end else if (rd_even && poll_q) begin
         poll_q <= 1'b0;
         if (grant_vld_i) begin
            isr_q[grant_lvl_i] <= 1'b1;
            ack_vec_q          <= {base_q, grant_lvl_i};
            vec_own_q          <= own_next;
         end
      end
   end

   always_comb begin
      if (a0_i)
         rdata_o = BUS_W'(imr_q);
      else if (poll_q)
         rdata_o = {grant_vld_i, {PAD_W{1'b0}}, (grant_vld_i ? grant_lvl_i : LW'(N - 1))};
      else if (sel_isr_q)
         rdata_o = BUS_W'(isr_q);
      else
         rdata_o = BUS_W'(irr_i);
   end

   assign imr_o     = imr_q;
   assign isr_o     = isr_q;
   assign ack_vec_o = ack_vec_q;
   assign vec_own_o = vec_own_q;

   AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      is_init |=> (imr_q == '0) && (isr_q == '0)); // R2

   AST_EOI_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (is_eoi && (isr_q != '0)) |=> ($countones(isr_q) + 1 == $countones($past(isr_q)))); // R10

   AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_clr_o)); // R7

   AST_POLL_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_even && poll_q) |=> !poll_q); // R7

   AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(imr_q)); // R3

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int NUM_LINES = 8,
   parameter bit IS_SLAVE  = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_a0,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [7:0]           bus_wdata,
   output logic [7:0]           bus_rdata,
   input  logic [NUM_LINES-1:0] irq_lines,
   output logic                 irq_out,
   output logic [7:0]           ack_vector,
   output logic                 vec_own,
   output logic [7:0]           link_cfg
);

   localparam int LW = $clog2(NUM_LINES);

   generate
      if (NUM_LINES != 8) begin : g_bad_lines
         $error("prio_irq_ctrl: the register layout requires NUM_LINES == 8");
      end
   endgenerate

   logic [NUM_LINES-1:0] irr;
   logic [NUM_LINES-1:0] imr;
   logic [NUM_LINES-1:0] isr;
   logic [NUM_LINES-1:0] ack_clr;
   logic                 grant_vld;
   logic [LW-1:0]        grant_lvl;
   logic                 isr_vld;
   logic [LW-1:0]        isr_lvl;

   prio_irq_reqlatch #(.N(NUM_LINES)) u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .lines_i   (irq_lines),
      .ack_clr_i (ack_clr),
      .irr_o     (irr)
   );

   prio_irq_resolver #(.N(NUM_LINES), .LW(LW)) u_res (
      .clk         (clk),
      .rst_n       (rst_n),
      .irr_i       (irr),
      .imr_i       (imr),
      .isr_i       (isr),
      .grant_vld_o (grant_vld),
      .grant_lvl_o (grant_lvl),
      .isr_vld_o   (isr_vld),
      .isr_lvl_o   (isr_lvl),
      .irq_o       (irq_out)
   );

   prio_irq_seq #(.N(NUM_LINES), .LW(LW), .IS_SLAVE(IS_SLAVE)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .a0_i        (bus_a0),
      .wr_i        (bus_wr),
      .rd_i        (bus_rd),
      .wdata_i     (bus_wdata),
      .rdata_o     (bus_rdata),
      .irr_i       (irr),
      .grant_vld_i (grant_vld),
      .grant_lvl_i (grant_lvl),
      .isr_vld_i   (isr_vld),
      .isr_lvl_i   (isr_lvl),
      .imr_o       (imr),
      .isr_o       (isr),
      .ack_clr_o   (ack_clr),
      .ack_vec_o   (ack_vector),
      .vec_own_o   (vec_own),
      .link_cfg_o  (link_cfg)
   );

endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic a0 = 1'b0;
   logic [7:0] wdata = '0;
   logic m_wr = 1'b0, m_rd = 1'b0, s_wr = 1'b0, s_rd = 1'b0;
   logic [7:0] m_lines = '0, s_lines = '0;
   logic [7:0] m_rdata, s_rdata, m_vec, s_vec, m_link, s_link;
   logic m_irq, s_irq, m_own, s_own;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   prio_irq_ctrl #(.NUM_LINES(8), .IS_SLAVE(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_a0(a0), .bus_wr(m_wr), .bus_rd(m_rd),
      .bus_wdata(wdata), .bus_rdata(m_rdata), .irq_lines(m_lines), .irq_out(m_irq),
      .ack_vector(m_vec), .vec_own(m_own), .link_cfg(m_link));

   prio_irq_ctrl #(.NUM_LINES(8), .IS_SLAVE(1'b1)) slv_i (
      .clk(clk), .rst_n(rst_n), .bus_a0(a0), .bus_wr(s_wr), .bus_rd(s_rd),
      .bus_wdata(wdata), .bus_rdata(s_rdata), .irq_lines(s_lines), .irq_out(s_irq),
      .ack_vector(s_vec), .vec_own(s_own), .link_cfg(s_link));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input bit slv, input bit adr, input logic [7:0] d);
      @(negedge clk);
      a0 = adr;
      wdata = d;
      if (slv) s_wr = 1'b1; else m_wr = 1'b1;
      @(negedge clk);
      m_wr = 1'b0;
      s_wr = 1'b0;
   endtask

   task automatic rd(input bit slv, input bit adr, output logic [7:0] d);
      @(negedge clk);
      a0 = adr;
      if (slv) s_rd = 1'b1; else m_rd = 1'b1;
      #1 d = slv ? s_rdata : m_rdata;
      @(negedge clk);
      m_rd = 1'b0;
      s_rd = 1'b0;
   endtask

   task automatic setm(input logic [7:0] v);
      @(negedge clk);
      m_lines = v;
      @(negedge clk);
   endtask

   task automatic sets(input logic [7:0] v);
      @(negedge clk);
      s_lines = v;
      @(negedge clk);
   endtask

   function automatic logic [7:0] poll_byte(input logic [7:0] eff);
      for (int i = 0; i < 8; i++)
         if (eff[i]) return 8'h80 | 8'(i);
      return 8'h07;
   endfunction

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", {7'b0, m_irq}, 8'h00);
      rd(0, 1, r); chk("R1 mask", r, 8'hFF);
      rd(0, 0, r); chk("R1 irr", r, 8'h00);

      // R2 full setup on both
      wr(0, 0, 8'h11); wr(0, 1, 8'h20); wr(0, 1, 8'h04); wr(0, 1, 8'h01);
      rd(0, 1, r); chk("R2 mask cleared", r, 8'h00);
      chk("R4 master link", m_link, 8'h04);
      wr(1, 0, 8'h11); wr(1, 1, 8'h28); wr(1, 1, 8'hFA); wr(1, 1, 8'h01);
      rd(1, 1, r); chk("R2 slave mask cleared", r, 8'h00);
      chk("R4 slave link", s_link, 8'h02);

      // R3 mask
      wr(0, 1, 8'h5A); rd(0, 1, r); chk("R3 mask load", r, 8'h5A);
      wr(0, 1, 8'h00);

      // R5 edge and drop
      setm(8'h10); rd(0, 0, r); chk("R5 edge sets", r, 8'h10);
      setm(8'h00); rd(0, 0, r); chk("R5 fall clears", r, 8'h00);
      setm(8'h10);
      wr(0, 0, 8'h0C); rd(0, 0, r); chk("R7 poll lvl4", r, 8'h84);
      chk("R11 vector", m_vec, 8'h24); chk("R11 own", {7'b0, m_own}, 8'h01);
      rd(0, 0, r); chk("R5 ack clears held line", r, 8'h00);
      wr(0, 0, 8'h0B); rd(0, 0, r); chk("R9 isr select", r, 8'h10);
      rd(0, 0, r); chk("R9 select persists", r, 8'h10);
      wr(0, 0, 8'h20); rd(0, 0, r); chk("R10 eoi", r, 8'h00);
      setm(8'h00);

      // R6 in-service gating, R10 ordering
      setm(8'h08); wr(0, 0, 8'h0C); rd(0, 0, r); chk("R7 poll lvl3", r, 8'h83);
      setm(8'h28); chk("R6 blocked by isr", {7'b0, m_irq}, 8'h00);
      setm(8'h2A); chk("R6 outranks isr", {7'b0, m_irq}, 8'h01);
      wr(0, 0, 8'h0C); rd(0, 0, r); chk("R7 poll lvl1", r, 8'h81);
      chk("R11 vector lvl1", m_vec, 8'h21);
      rd(0, 0, r); chk("R9 kept after poll cmd", r, 8'h0A);
      wr(0, 0, 8'h60); rd(0, 0, r); chk("R10 other code ignored", r, 8'h0A);
      wr(0, 0, 8'h20); rd(0, 0, r); chk("R10 clears top only", r, 8'h08);
      chk("R6 still blocked", {7'b0, m_irq}, 8'h00);
      wr(0, 0, 8'h20); rd(0, 0, r); chk("R10 second eoi", r, 8'h00);
      chk("R6 unblocked", {7'b0, m_irq}, 8'h01);
      wr(0, 0, 8'h20); rd(0, 0, r); chk("R10 eoi on empty", r, 8'h00);
      wr(0, 0, 8'h0C); rd(0, 0, r); chk("R7 poll lvl5", r, 8'h85);
      wr(0, 0, 8'h20); setm(8'h00);

      // R11 cascaded level on master
      setm(8'h04); wr(0, 0, 8'h0C); rd(0, 0, r); chk("R7 poll lvl2", r, 8'h82);
      chk("R11 cascade vector", m_vec, 8'h22); chk("R11 cascade own", {7'b0, m_own}, 8'h00);
      wr(0, 0, 8'h20); setm(8'h00);

      // R7 odd read keeps poll armed
      setm(8'h40); wr(0, 0, 8'h0C);
      rd(0, 1, r); chk("R7 odd read mask", r, 8'h00);
      rd(0, 0, r); chk("R7 poll survives odd read", r, 8'h86);
      wr(0, 0, 8'h20); setm(8'h00);

      // R8 empty and spurious
      wr(0, 0, 8'h0C); rd(0, 0, r); chk("R8 empty poll", r, 8'h07);
      rd(0, 0, r); chk("R8 no isr on empty", r, 8'h00);
      setm(8'h80); chk("R8 lvl7 raises irq", {7'b0, m_irq}, 8'h01);
      setm(8'h00); chk("R5 lvl7 drop", {7'b0, m_irq}, 8'h00);
      wr(0, 0, 8'h0C); rd(0, 0, r); chk("R8 spurious reads 7", r, 8'h07);
      rd(0, 0, r); chk("R8 spurious isr7 clear", r, 8'h00);
      setm(8'h80); wr(0, 0, 8'h0C); rd(0, 0, r); chk("R8 real lvl7", r, 8'h87);
      rd(0, 0, r); chk("R8 real isr7 set", r, 8'h80);
      wr(0, 0, 8'h20); setm(8'h00);

      // R9 back to request register
      wr(0, 0, 8'h0A); setm(8'h30); rd(0, 0, r); chk("R9 irr select", r, 8'h30);
      setm(8'h00);

      // R3 mask blocks irq
      wr(0, 1, 8'h01); setm(8'h01); chk("R3 masked line", {7'b0, m_irq}, 8'h00);
      wr(0, 1, 8'h00); chk("R3 unmasked line", {7'b0, m_irq}, 8'h01);
      setm(8'h00);

      // R11 slave vector
      sets(8'h02); chk("R6 slave irq", {7'b0, s_irq}, 8'h01);
      wr(1, 0, 8'h0C); rd(1, 0, r); chk("R7 slave poll", r, 8'h81);
      chk("R11 slave vector", s_vec, 8'h29); chk("R11 slave own", {7'b0, s_own}, 8'h01);
      wr(1, 0, 8'h20); sets(8'h00);

      // R2 shortened sequences on the slave
      wr(1, 0, 8'h13); wr(1, 1, 8'h40); wr(1, 1, 8'h01); wr(1, 1, 8'h5A);
      rd(1, 1, r); chk("R2 no cascade byte", r, 8'h5A);
      chk("R4 link kept", s_link, 8'h02);
      wr(1, 0, 8'h12); wr(1, 1, 8'h48); wr(1, 1, 8'h33);
      rd(1, 1, r); chk("R2 no cascade no mode", r, 8'h33);
      sets(8'h08); wr(1, 0, 8'h0C); rd(1, 0, r); chk("R7 slave poll lvl3", r, 8'h83);
      chk("R2 new base in vector", s_vec, 8'h4B);
      wr(1, 0, 8'h20); sets(8'h00);

      // R6/R7 sweep over all request patterns
      wr(0, 0, 8'h0B);
      for (int mi = 0; mi < 2; mi++) begin
         logic [7:0] mk;
         mk = (mi == 0) ? 8'h00 : 8'h81;
         wr(0, 1, mk);
         for (int p = 0; p < 256; p++) begin
            logic [7:0] eff;
            logic [7:0] exp_p;
            eff = 8'(p) & ~mk;
            exp_p = poll_byte(eff);
            setm(8'h00);
            setm(8'(p));
            chk("R6 sweep irq", {7'b0, m_irq}, {7'b0, (eff != 0)});
            wr(0, 0, 8'h0C); rd(0, 0, r); chk("R7 sweep poll", r, exp_p);
            rd(0, 0, r); chk("R7 sweep isr", r, (eff != 0) ? (8'h01 << exp_p[2:0]) : 8'h00);
            wr(0, 0, 8'h20);
         end
      end
      setm(8'h00);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule